// File: doc/BRIEF.md
# Oscillator-count calibration divider for a seconds timebase

This block turns a free-running crystal clock (nominally 32768 Hz) into a corrected one-pulse-per-second tick and a minute-boundary pulse. It splits the divider chain at a coarse stage that divides by 128. Drift is corrected by changing how many coarse-stage periods make up one selected second, so the correction comes in whole 128-cycle steps. A signed calibration setting controls the correction. It has a 5-bit magnitude and a direction bit.

Correction is sparse. Time is grouped into 64-minute correction periods. A magnitude of N selects the first 2N minutes of each period, so at most 62 minutes are selected. In each selected minute, only the first second is altered. When the block is speeding up, that second loses two coarse periods (256 cycles at default sizes). When it is slowing down, that second gains one coarse period (128 cycles). Each magnitude step therefore moves a period of 125,829,120 cycles by -512 or +256 cycles, which is about +4.07 or -2.03 ppm.

The calibration inputs are plain control levels, with no handshake. They are sampled once per period, at the boundary. The calendar logic downstream consumes the tick outputs as single-cycle strobes and cannot stall them.

Top module: `rtc_cal_trim`

## Requirements
- R1: While reset is held, both outputs are low. After reset is released, the first `sec_tick` comes exactly OSC_HZ cycles later. The first 64-minute period after reset carries no correction, whatever the calibration inputs are.
- R2: A second that is not corrected lasts exactly OSC_HZ oscillator cycles, counted from one `sec_tick` to the next.
- R3: `min_tick` is high only together with `sec_tick`, and only on every SEC_PER_MIN-th `sec_tick`.
- R4: The calibration inputs are sampled only on the clock edge that ends minute 63 of a period. A change made in the middle of a period has no effect until the following period.
- R5: With a sampled magnitude N, minutes 0 to 2N-1 of the period are corrected. All other minutes are left at their nominal length.
- R6: Inside a corrected minute, only second 0 (the first second after the minute boundary) differs from nominal.
- R7: When `cal_speedup` is 1, a corrected second is shortened by 2*STAGE_DIV cycles.
- R8: When `cal_speedup` is 0, a corrected second is lengthened by STAGE_DIV cycles.
- R9: A magnitude of 0 leaves every second nominal, whatever the direction bit is.
- R10: A whole 64-minute period lasts 64*SEC_PER_MIN*OSC_HZ cycles, adjusted by -4*STAGE_DIV*N cycles when speeding up or +2*STAGE_DIV*N cycles when slowing down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock. Each rising edge is one oscillator count. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| cal_mag | input | 5 | Calibration magnitude, 0 to 31. |
| cal_speedup | input | 1 | Direction: 1 speeds the clock up (shortens seconds), 0 slows it down. |
| sec_tick | output | 1 | Single-cycle strobe on the last cycle of each corrected second. |
| min_tick | output | 1 | Single-cycle strobe, coincident with the last `sec_tick` of each minute. |

## Verification
The properties assume that the calibration inputs are synchronous to `clk_osc` and steady across the edge that closes a period. They also assume that OSC_HZ divides evenly by STAGE_DIV into more than two coarse periods. The stimulus changes the calibration only one cycle after an observed period boundary, or in the middle of a period. This keeps every sampling edge clean. The bench uses a shrunken configuration (4-cycle coarse stage, 8 coarse periods per second, 2 seconds per minute). With that configuration it can sweep every magnitude and both directions over whole 64-minute periods.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  // width of the calibration magnitude
  localparam int CAL_W = 5;
  // largest count of corrected minutes in one correction period
  localparam int MAX_TRIM_MINUTES = 2 * ((1 << CAL_W) - 1);

  typedef enum logic [1:0] {
    TRIM_NONE  = 2'd0,
    TRIM_SHORT = 2'd1,
    TRIM_LONG  = 2'd2
  } trim_e;
endpackage

// File: rtl/rtc_cal_prescale.sv
module rtc_cal_prescale #(
  parameter int DIV = 128
) (
  input  logic clk_osc,
  input  logic rst_n,
  output logic stage_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign stage_tick = (cnt == LAST);

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (stage_tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_cal_secdiv.sv
module rtc_cal_secdiv #(
  parameter int TICKS = 256
) (
  input  logic               clk_osc,
  input  logic               rst_n,
  input  logic               stage_tick,
  input  rtc_cal_pkg::trim_e trim,
  output logic               sec_end
);
  import rtc_cal_pkg::*;

  localparam int CW = $clog2(TICKS + 2);
  localparam logic [CW-1:0] END_NOM   = CW'(TICKS - 1);
  localparam logic [CW-1:0] END_SHORT = CW'(TICKS - 3);
  localparam logic [CW-1:0] END_LONG  = CW'(TICKS);

  logic [CW-1:0] cnt;
  logic [CW-1:0] end_idx;

  // trim only changes on sec_end, so it is constant over each second
  always_comb begin
    unique case (trim)
      TRIM_SHORT: end_idx = END_SHORT;
      TRIM_LONG:  end_idx = END_LONG;
      default:    end_idx = END_NOM;
    endcase
  end

  assign sec_end = stage_tick && (cnt == end_idx);

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (sec_end)    cnt <= '0;
    else if (stage_tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_cal_seq.sv
module rtc_cal_seq #(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64
) (
  input  logic                          clk_osc,
  input  logic                          rst_n,
  input  logic                          sec_end,
  input  logic [rtc_cal_pkg::CAL_W-1:0] cal_mag,
  input  logic                          cal_speedup,
  output rtc_cal_pkg::trim_e            trim,
  output logic                          min_end
);
  import rtc_cal_pkg::*;

  localparam int SW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MW = (MIN_PER_CYCLE > 1) ? $clog2(MIN_PER_CYCLE) : 1;
  localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(MIN_PER_CYCLE - 1);

  logic [SW-1:0]    sec_idx;
  logic [MW-1:0]    min_idx;
  logic [CAL_W-1:0] hold_mag;
  logic             hold_up;
  logic             cyc_end;
  logic             selected;

  assign min_end = sec_end && (sec_idx == SEC_LAST);
  assign cyc_end = min_end && (min_idx == MIN_LAST);

  // second 0 of minutes 0 .. 2N-1 is the corrected one
  assign selected = (sec_idx == '0) && (int'(min_idx) < 2 * int'(hold_mag));
  assign trim = selected ? (hold_up ? TRIM_SHORT : TRIM_LONG) : TRIM_NONE;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      sec_idx <= '0;
      min_idx <= '0;
    end else if (sec_end) begin
      if (min_end) begin
        sec_idx <= '0;
        min_idx <= cyc_end ? '0 : min_idx + 1'b1;
      end else begin
        sec_idx <= sec_idx + 1'b1;
      end
    end
  end

  // calibration captured only at the period boundary
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      hold_mag <= '0;
      hold_up  <= 1'b0;
    end else if (cyc_end) begin
      hold_mag <= cal_mag;
      hold_up  <= cal_speedup;
    end
  end
endmodule

// File: rtl/rtc_cal_trim.sv
module rtc_cal_trim #(
  parameter int OSC_HZ        = 32768,
  parameter int STAGE_DIV     = 128,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64
) (
  input  logic                          clk_osc,
  input  logic                          rst_n,
  input  logic [rtc_cal_pkg::CAL_W-1:0] cal_mag,
  input  logic                          cal_speedup,
  output logic                          sec_tick,
  output logic                          min_tick
);
  import rtc_cal_pkg::*;

  localparam int TICKS_PER_SEC = OSC_HZ / STAGE_DIV;

  logic  stage_tick;
  logic  sec_end;
  logic  min_end;
  trim_e trim;

  rtc_cal_prescale #(.DIV(STAGE_DIV)) u_prescale (
    .clk_osc    (clk_osc),
    .rst_n      (rst_n),
    .stage_tick (stage_tick)
  );

  rtc_cal_secdiv #(.TICKS(TICKS_PER_SEC)) u_secdiv (
    .clk_osc    (clk_osc),
    .rst_n      (rst_n),
    .stage_tick (stage_tick),
    .trim       (trim),
    .sec_end    (sec_end)
  );

  rtc_cal_seq #(
    .SEC_PER_MIN   (SEC_PER_MIN),
    .MIN_PER_CYCLE (MIN_PER_CYCLE)
  ) u_seq (
    .clk_osc     (clk_osc),
    .rst_n       (rst_n),
    .sec_end     (sec_end),
    .cal_mag     (cal_mag),
    .cal_speedup (cal_speedup),
    .trim        (trim),
    .min_end     (min_end)
  );

  assign sec_tick = sec_end;
  assign min_tick = min_end;
endmodule

// File: rtl/rtc_cal_trim_chk.sv
module rtc_cal_trim_chk #(
  parameter int OSC_HZ        = 32768,
  parameter int STAGE_DIV     = 128,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64
) (
  input logic clk_osc,
  input logic rst_n,
  input logic sec_tick,
  input logic min_tick
);
  localparam int LEN_NOM   = OSC_HZ;
  localparam int LEN_SHORT = OSC_HZ - 2 * STAGE_DIV;
  localparam int LEN_LONG  = OSC_HZ + STAGE_DIV;

  int gap;
  int secs_in_min;
  int min_cnt;
  int adj_cnt;
  logic after_min;
  int len;

  assign len = gap + 1;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      gap         <= 0;
      secs_in_min <= 0;
      min_cnt     <= 0;
      adj_cnt     <= 0;
      after_min   <= 1'b1;
    end else begin
      gap <= sec_tick ? 0 : gap + 1;
      if (sec_tick) begin
        after_min   <= min_tick;
        secs_in_min <= min_tick ? 0 : secs_in_min + 1;
        if (min_tick && min_cnt == MIN_PER_CYCLE - 1) begin
          min_cnt <= 0;
          adj_cnt <= 0;
        end else begin
          if (min_tick) min_cnt <= min_cnt + 1;
          if (len != LEN_NOM) adj_cnt <= adj_cnt + 1;
        end
      end
    end
  end

  // R3
  min_with_sec_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    min_tick |-> sec_tick);

  // R3
  secs_per_min_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    min_tick |-> (secs_in_min == SEC_PER_MIN - 1));

  // R2
  sec_len_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    sec_tick |-> (len == LEN_NOM || len == LEN_SHORT || len == LEN_LONG));

  // R8
  gap_limit_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    gap < LEN_LONG);

  // R6
  first_sec_only_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (sec_tick && len != LEN_NOM) |-> after_min);

  // R5
  adj_bound_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    adj_cnt <= rtc_cal_pkg::MAX_TRIM_MINUTES);
endmodule

bind rtc_cal_trim rtc_cal_trim_chk #(
  .OSC_HZ        (OSC_HZ),
  .STAGE_DIV     (STAGE_DIV),
  .SEC_PER_MIN   (SEC_PER_MIN),
  .MIN_PER_CYCLE (MIN_PER_CYCLE)
) u_chk (
  .clk_osc  (clk_osc),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .min_tick (min_tick)
);

// File: tb/rtc_cal_trim_bench.sv
module rtc_cal_trim_bench;
  localparam int OSC = 32;
  localparam int DIV = 4;
  localparam int SPM = 2;
  localparam int MPC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cal_mag = 5'd0;
  logic       cal_up = 1'b0;
  logic       sec_tick;
  logic       min_tick;

  always #2 clk = ~clk;

  rtc_cal_trim #(
    .OSC_HZ(OSC), .STAGE_DIV(DIV), .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC)
  ) u_rtc_cal_trim (
    .clk_osc(clk), .rst_n(rst_n), .cal_mag(cal_mag), .cal_speedup(cal_up),
    .sec_tick(sec_tick), .min_tick(min_tick)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // reference model state, advanced at negedges
  bit     run = 0;
  longint n = 0, last = 0, cyc_sum = 0;
  int     sidx = 0, midx = 0, am = 0, ncyc = 0, r4_cyc = -1;
  bit     as_up = 0, first = 1;

  always @(negedge clk) begin
    if (run) begin
      n++;
      if (min_tick && !sec_tick)
        check(0, "R3", "min_tick without sec_tick", 1, 0);
      if (sec_tick) begin
        longint len, exp;
        bit     corr;
        string  tag;
        len  = n - last;
        last = n;
        corr = (sidx == 0) && (midx < 2 * am);
        exp  = OSC + (corr ? (as_up ? -2 * DIV : DIV) : 0);
        if (first)                 tag = "R1";
        else if (ncyc == r4_cyc)   tag = "R4";
        else if (corr)             tag = as_up ? "R7" : "R8";
        else if (sidx == 0 && am == 0) tag = "R9";
        else if (sidx == 0)        tag = "R5";
        else if (am != 0 && midx < 2 * am) tag = "R6";
        else                       tag = "R2";
        first = 0;
        check(len == exp, tag, "second length", len, exp);
        check(min_tick == (sidx == SPM - 1), "R3", "minute strobe",
              min_tick, sidx == SPM - 1);
        cyc_sum += len;
        if (sidx == SPM - 1) begin
          sidx = 0;
          midx++;
          if (midx == MPC) begin
            longint texp;
            texp = longint'(MPC) * SPM * OSC + (as_up ? -4 * DIV * am : 2 * DIV * am);
            check(cyc_sum == texp, "R10", "period length", cyc_sum, texp);
            cyc_sum = 0;
            midx    = 0;
            am      = cal_mag;
            as_up   = cal_up;
            ncyc++;
          end
        end else begin
          sidx++;
        end
      end
    end
  end

  task automatic wait_boundary();
    int s;
    s = ncyc;
    wait (ncyc != s);
    @(posedge clk);
    #1;
  endtask

  task automatic set_cal(input int m, input bit up);
    cal_mag = 5'(m);
    cal_up  = up;
  endtask

  initial begin
    // R1: reset state, calibration present but must not apply in period 0
    set_cal(5, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(sec_tick == 0 && min_tick == 0, "R1", "outputs in reset",
            {sec_tick, min_tick}, 0);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    run   = 1;
    // sweep every magnitude, direction alternating
    for (int m = 0; m < 32; m++) begin
      wait_boundary();
      set_cal(m, m[0]);
    end
    wait_boundary();
    set_cal(31, 0);
    wait_boundary();
    set_cal(0, 1);
    // R4: change in the middle of a period
    wait_boundary();
    set_cal(3, 1);
    wait (midx == 20);
    @(posedge clk);
    #1;
    set_cal(7, 0);
    r4_cyc = ncyc + 1;
    wait_boundary();
    set_cal(0, 0);
    wait_boundary();
    wait_boundary();
    finish_run();
  end

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule